// File: doc/BRIEF.md
# Packed-Lane Saturating Adder

This block adds two 64-bit operands that are treated as a set of packed, independent integer lanes. A two-bit lane-size input divides the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. The addition is done in a single wide byte-segmented adder. The carry into the first byte of every lane is forced to zero, so no lane can disturb its neighbour.

A saturate-enable input picks between plain two's-complement wraparound and clamping arithmetic. A signedness input picks whether lanes are read as signed or unsigned values. When clamping is enabled and a lane's true sum falls outside its range, the lane is replaced by the extreme value in the direction of the true result, and that lane's flag bit is raised. Results and flags are registered. The output valid strobe follows the input valid strobe one cycle later.

Top module: `simd_sat_add`

## Requirements
- R1: Lane size encoding on `mode_i` is 2'b00 for 8-bit lanes, 2'b01 for 16-bit, 2'b10 for 32-bit and 2'b11 for one 64-bit lane. Lane k occupies bits [k*W +: W]. A carry out of any lane never reaches the next lane.
- R2: With `sat_en_i` low, every lane result is the low W bits of the lane sum, so two large positive signed lanes may produce a negative result, and all bits of `sat_o` are 0.
- R3: With saturation enabled and signed lanes, a lane sum above the signed maximum yields 0 followed by W-1 ones (for example 8'h7F).
- R4: With saturation enabled and signed lanes, a lane sum below the signed minimum yields 1 followed by W-1 zeros (for example 8'h80).
- R5: With saturation enabled and unsigned lanes, a lane sum above 2^W-1 yields all ones.
- R6: Bit k of `sat_o` is 1 exactly when lane k was clamped. Bits at or above the number of lanes are 0.
- R7: `valid_o` equals `valid_i` from one clock earlier. `result_o` and `sat_o` take the sum of the operands presented with `valid_i` high, and hold their values in cycles after `valid_i` was low.
- R8: While `rst_n` is low, `valid_o`, `result_o` and `sat_o` are all zero.
- R9: In mode 2'b11 the whole word is one lane, and saturation and wraparound apply to the full 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid |
| mode_i | input | 2 | Lane size select |
| sat_en_i | input | 1 | 1 = clamp on overflow, 0 = wrap |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| a_i | input | 64 | Packed operand A |
| b_i | input | 64 | Packed operand B |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 64 | Packed lane sums |
| sat_o | output | 8 | Per-lane clamp flags, bit k for lane k |

## Verification
The bench adds 8'hFF to 8'h01 in adjacent byte lanes. A design that leaks carries across boundaries would show 16'h0100 where 16'h0000 is expected in 8-bit mode. It pushes lanes just past the signed maximum and the signed minimum, and just past the unsigned maximum, in every lane size. A design that clamps in the wrong direction, or uses the signed limit for unsigned data, returns the wrong extreme. The bench also sets a flag only where a lane actually clamped, in lanes and modes where the result would otherwise look fine. It checks that results hold in idle cycles, so a register that loads without `valid_i` is exposed. Random operands in all modes and signedness settings are compared against an arithmetic model.

// File: rtl/simd_pkg.sv
package simd_pkg;
    typedef enum logic [1:0] {
        LANE_B8  = 2'b00,
        LANE_B16 = 2'b01,
        LANE_B32 = 2'b10,
        LANE_B64 = 2'b11
    } lane_mode_e;

    function automatic int unsigned lane_bytes(input logic [1:0] mode);
        return 32'd1 << mode;
    endfunction
endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
    parameter int DATA_W = 64,
    localparam int NB = DATA_W / 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [NB-1:0]     start_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [NB-1:0]     cout_o,
    output logic [NB-1:0]     sovf_o
);
    logic       run_c;
    logic       cin;
    logic [8:0] seg;

    always_comb begin
        run_c  = 1'b0;
        cin    = 1'b0;
        seg    = '0;
        sum_o  = '0;
        cout_o = '0;
        sovf_o = '0;
        for (int i = 0; i < NB; i++) begin
            cin = start_i[i] ? 1'b0 : run_c;
            seg = {1'b0, a_i[8*i +: 8]} + {1'b0, b_i[8*i +: 8]} + {8'b0, cin};
            sum_o[8*i +: 8] = seg[7:0];
            cout_o[i] = seg[8];
            sovf_o[i] = (a_i[8*i+7] == b_i[8*i+7]) && (seg[7] != a_i[8*i+7]);
            run_c = seg[8];
        end
    end
endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp #(
    parameter int DATA_W = 64,
    localparam int NB = DATA_W / 8
) (
    input  logic [DATA_W-1:0] sum_i,
    input  logic [NB-1:0]     cout_i,
    input  logic [NB-1:0]     sovf_i,
    input  logic [1:0]        mode_i,
    input  logic              sat_en_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] result_o,
    output logic [NB-1:0]     flag_o
);
    wire [DATA_W-1:0] cand_res  [4];
    wire [NB-1:0]     cand_flag [4];

    for (genvar w = 0; w < 4; w++) begin : g_size
        localparam int LB = 1 << w;
        if (LB <= NB) begin : g_fit
            localparam int NL = NB / LB;
            localparam int W  = LB * 8;
            for (genvar l = 0; l < NL; l++) begin : g_lane
                localparam int TOP = l * LB + LB - 1;
                localparam int LO  = l * W;
                wire         s_msb = sum_i[LO+W-1];
                wire         ovf   = signed_i ? sovf_i[TOP] : cout_i[TOP];
                wire         hit   = sat_en_i & ovf;
                wire [W-1:0] clamp = !signed_i ? {W{1'b1}} :
                                     s_msb ? {1'b0, {(W-1){1'b1}}} :
                                             {1'b1, {(W-1){1'b0}}};
                assign cand_res[w][LO +: W] = hit ? clamp : sum_i[LO +: W];
                assign cand_flag[w][l]      = hit;
            end
            if (NL < NB) begin : g_pad
                assign cand_flag[w][NB-1:NL] = '0;
            end
        end else begin : g_skip
            assign cand_res[w]  = sum_i;
            assign cand_flag[w] = '0;
        end
    end

    assign result_o = cand_res[mode_i];
    assign flag_o   = cand_flag[mode_i];
endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add #(
    parameter int DATA_W = 64,
    localparam int NB = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [1:0]        mode_i,
    input  logic              sat_en_i,
    input  logic              signed_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic [NB-1:0]     sat_o
);
    import simd_pkg::*;

    logic [NB-1:0]     lane_start;
    logic [DATA_W-1:0] raw_sum;
    logic [NB-1:0]     byte_cout;
    logic [NB-1:0]     byte_sovf;
    logic [DATA_W-1:0] next_res;
    logic [NB-1:0]     next_flag;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            lane_start[i] = ((i & (lane_bytes(mode_i) - 1)) == 0);
        end
    end

    simd_seg_adder #(.DATA_W(DATA_W)) u_add (
        .a_i    (a_i),
        .b_i    (b_i),
        .start_i(lane_start),
        .sum_o  (raw_sum),
        .cout_o (byte_cout),
        .sovf_o (byte_sovf)
    );

    simd_lane_clamp #(.DATA_W(DATA_W)) u_clamp (
        .sum_i   (raw_sum),
        .cout_i  (byte_cout),
        .sovf_i  (byte_sovf),
        .mode_i  (mode_i),
        .sat_en_i(sat_en_i),
        .signed_i(signed_i),
        .result_o(next_res),
        .flag_o  (next_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            result_o <= '0;
            sat_o    <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                result_o <= next_res;
                sat_o    <= next_flag;
            end
        end
    end
endmodule

// File: rtl/simd_sat_add_chk.sv
module simd_sat_add_chk #(
    parameter int DATA_W = 64,
    localparam int NB = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [1:0]        mode_i,
    input logic              sat_en_i,
    input logic              signed_i,
    input logic [DATA_W-1:0] a_i,
    input logic              valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic [NB-1:0]     sat_o
);
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(valid_i)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_i)) |-> ($stable(result_o) && $stable(sat_o)));

    a_r2_wrap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && !$past(sat_en_i)) |-> (sat_o == '0));

    a_r6_single_lane_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && ($past(mode_i) == 2'b11)) |-> (sat_o[NB-1:1] == '0));

    a_r5_unsigned_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(sat_en_i) && !$past(signed_i)
         && ($past(mode_i) == 2'b00) && sat_o[0]) |-> (result_o[7:0] == 8'hFF));

    a_r3_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(sat_en_i) && $past(signed_i)
         && ($past(mode_i) == 2'b00) && !$past(a_i[7]) && sat_o[0]) |-> (result_o[7:0] == 8'h7F));

    a_r4_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(sat_en_i) && $past(signed_i)
         && ($past(mode_i) == 2'b00) && $past(a_i[7]) && sat_o[0]) |-> (result_o[7:0] == 8'h80));

    always_comb begin
        if (!rst_n) begin
            a_r8_reset_clear: assert (!valid_o && result_o == '0 && sat_o == '0);
        end
    end
endmodule

bind simd_sat_add simd_sat_add_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .mode_i  (mode_i),
    .sat_en_i(sat_en_i),
    .signed_i(signed_i),
    .a_i     (a_i),
    .valid_o (valid_o),
    .result_o(result_o),
    .sat_o   (sat_o)
);

// File: tb/sim_simd_sat_add.sv
module sim_simd_sat_add;
    localparam int DATA_W = 64;
    localparam int NB = DATA_W / 8;

    typedef struct {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [NB-1:0]     flg;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid_i = 1'b0;
    logic [1:0]        mode_i = 2'b00;
    logic              sat_en_i = 1'b0;
    logic              signed_i = 1'b0;
    logic [DATA_W-1:0] a_i = '0;
    logic [DATA_W-1:0] b_i = '0;
    logic              valid_o;
    logic [DATA_W-1:0] result_o;
    logic [NB-1:0]     sat_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb[$];
    logic [DATA_W-1:0] last_res = '0;
    logic [NB-1:0]     last_flg = '0;

    always #10 clk = ~clk;

    simd_sat_add #(.DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
        .sat_en_i(sat_en_i), .signed_i(signed_i), .a_i(a_i), .b_i(b_i),
        .valid_o(valid_o), .result_o(result_o), .sat_o(sat_o)
    );

    task automatic model(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                         input logic [1:0] mode, input logic sat, input logic sgn,
                         output logic [DATA_W-1:0] res, output logic [NB-1:0] flg);
        int w;
        int nl;
        logic signed [65:0] xa, xb, s, mx, mn, r;
        w  = 8 << mode;
        nl = DATA_W / w;
        res = '0;
        flg = '0;
        for (int l = 0; l < nl; l++) begin
            for (int k = 0; k < 66; k++) begin
                xa[k] = (k < w) ? a[l*w + k] : (sgn & a[l*w + w - 1]);
                xb[k] = (k < w) ? b[l*w + k] : (sgn & b[l*w + w - 1]);
            end
            s  = xa + xb;
            mx = sgn ? ((66'sd1 <<< (w - 1)) - 66'sd1) : ((66'sd1 <<< w) - 66'sd1);
            mn = sgn ? -(66'sd1 <<< (w - 1)) : 66'sd0;
            r  = s;
            if (sat && s > mx) begin r = mx; flg[l] = 1'b1; end
            if (sat && s < mn) begin r = mn; flg[l] = 1'b1; end
            for (int k = 0; k < w; k++) res[l*w + k] = r[k];
        end
    endtask

    task automatic drive(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                         input logic [1:0] mode, input logic sat, input logic sgn,
                         input string tag);
        exp_t e;
        @(negedge clk);
        valid_i = 1'b1; a_i = a; b_i = b; mode_i = mode; sat_en_i = sat; signed_i = sgn;
        model(a, b, mode, sat, sgn, e.res, e.flg);
        e.vld = 1'b1;
        e.tag = tag;
        last_res = e.res;
        last_flg = e.flg;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            @(negedge clk);
            valid_i = 1'b0;
            a_i = {$urandom, $urandom};
            b_i = {$urandom, $urandom};
            e.vld = 1'b0; e.res = last_res; e.flg = last_flg; e.tag = "R7 hold";
            sb.push_back(e);
        end
    endtask

    // monitor: output from the edge before this sample
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (valid_o !== e.vld) begin
                    errors++;
                    $display("FAIL R7 valid (%s): got %0b exp %0b", e.tag, valid_o, e.vld);
                end else if (result_o !== e.res || sat_o !== e.flg) begin
                    errors++;
                    $display("FAIL %s: got res %h flg %b exp res %h flg %b",
                             e.tag, result_o, sat_o, e.res, e.flg);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || result_o !== '0 || sat_o !== '0) begin
            errors++;
            $display("FAIL R8 reset: got %b %h %b exp 0 0 0", valid_o, result_o, sat_o);
        end
        rst_n = 1'b1;

        // R1 lane isolation
        drive(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b00, 1'b0, 1'b0, "R1 8-bit cut");
        drive(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b01, 1'b0, 1'b0, "R1 16-bit carry");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0, 1'b0, "R1 32-bit cut");
        // R2 wrap
        drive(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 1'b1, "R2 wrap signed");
        // R3 / R4 / R5 per size
        drive(64'h7F7F_7F7F_8080_8080, 64'h0101_0101_FFFF_FFFF, 2'b00, 1'b1, 1'b1, "R3 R4 8-bit");
        drive(64'h7FFF_8000_7FFF_8000, 64'h0001_FFFF_0001_FFFF, 2'b01, 1'b1, 1'b1, "R3 R4 16-bit");
        drive(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 2'b10, 1'b1, 1'b1, "R3 R4 32-bit");
        drive(64'hFFFF_FF00_FFFF_0000, 64'h0001_0001_0001_0001, 2'b00, 1'b1, 1'b0, "R5 8-bit");
        drive(64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0003, 2'b10, 1'b1, 1'b0, "R5 32-bit");
        // R6 flag only where clamped
        drive(64'h0000_7F00_0000_0000, 64'h0000_0100_0000_0000, 2'b00, 1'b1, 1'b1, "R6 one lane");
        drive(64'h7F00_0000_0000_0000, 64'h0080_0000_0000_0000, 2'b00, 1'b1, 1'b1, "R6 no clamp");
        // R9 single lane
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'b11, 1'b1, 1'b1, "R9 pos");
        drive(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, 1'b1, "R9 neg");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 2'b11, 1'b1, 1'b0, "R9 unsigned");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 2'b11, 1'b0, 1'b0, "R9 wrap");
        // R7 hold while idle
        idle(3);
        for (int i = 0; i < 200; i++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom),
                  1'($urandom), 1'($urandom), "R2 R6 random");
            if (i % 17 == 0) idle(1);
        end
        idle(3);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule